// File: doc/BRIEF.md
# Internal Data Memory Access Router

This block sits between a CPU's data-access stage and every place a data byte can live. Each request carries an address, an access kind (direct, indirect or external-move) and an optional write byte. The router sends it to one of five places: the lower scratch RAM, the upper scratch RAM that only indirect accesses can reach, the special function register file, the on-chip expanded RAM, or an external data bus with a 64 kB address space. The two scratch halves together form one 256-byte synchronous array. The expanded RAM is a 768-byte synchronous array.

Requests use a valid/ready handshake. An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the address, kind, write flag and write byte stable while `req_valid` is high and `req_ready` is low. Responses flow only one way: `rsp_valid` pulses for one cycle per accepted access, and it cannot be held back, so the requester must take it in that cycle. `rsp_rdata` carries meaning only for reads. An external access holds `req_ready` low until the external device acknowledges. This stalls the requester, and only one external access is ever outstanding.

Access kind codes on `req_kind`: 0 = direct, 1 = indirect, 2 = external-move, 3 = handled exactly as direct. The control input `xram_off` moves all external-move traffic off chip.

Top module: `dmem_router`

## Requirements
- R1: A direct or indirect access with address byte 00H–7FH reads or writes the same lower scratch RAM byte for both kinds.
- R2: An indirect access (req_kind 1) with address byte 80H–FFH reaches the upper scratch RAM and does not drive the SFR port.
- R3: A direct access (req_kind 0) with address byte 80H–FFH raises `sfr_en` with `sfr_addr` equal to the address byte. It never touches the upper scratch RAM, so a write to the SFR and a write to upper RAM at the same byte address each read back their own value.
- R4: An external-move access (req_kind 2) with address 0000H–02FFH and `xram_off` low reaches the on-chip expanded RAM and leaves `ext_req` low. The boundary addresses are 02FFH (on chip) and 0300H (external).
- R5: An external-move access with address 0300H or above goes to the external bus and presents all 16 address bits on `ext_addr`.
- R6: While `xram_off` is high, every external-move access goes to the external bus, including 0000H–02FFH, and the expanded RAM contents are left unchanged.
- R7: Every accepted access that stays on chip (scratch, SFR or expanded RAM) gives `rsp_valid` in the very next cycle, with read data for reads.
- R8: An external access raises `ext_req` in the cycle after acceptance. It holds `ext_req`, `ext_addr`, `ext_we` and `ext_wdata` stable until a cycle with `ext_ack` high. `req_ready` stays low throughout. `rsp_valid` follows in the cycle after the acknowledge, carrying the `ext_rdata` sampled with it.
- R9: Direct and indirect accesses use only address bits 7:0; bits 15:8 have no effect on routing or location.
- R10: Access kind code 3 is routed exactly as a direct access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xram_off | input | 1 | High: external-move accesses bypass the on-chip expanded RAM |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Router can accept a request |
| req_kind | input | 2 | 0 direct, 1 indirect, 2 external-move, 3 as direct |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid on reads |
| sfr_en | output | 1 | SFR access strobe |
| sfr_we | output | 1 | SFR write strobe qualifier |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write byte |
| sfr_rdata | input | 8 | SFR read byte, combinational from sfr_addr |
| ext_req | output | 1 | External access pending |
| ext_we | output | 1 | External write |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write byte |
| ext_ack | input | 1 | External access complete |
| ext_rdata | input | 8 | External read byte, sampled with ext_ack |

## Verification
The scratch and expanded RAMs are first filled, and then random accesses mix all four kind codes. Direct and indirect addresses carry random high bytes, which tells real 8-bit decoding apart from decoding that leaks the upper bits. External-move addresses are biased around the 02FFH/0300H edge while `xram_off` toggles at random. This separates on-chip hits from bus traffic, and the bench also checks where the traffic went, not only the data. A directed pair of writes to the same byte address, one direct and one indirect, followed by reads of both, tells separate SFR and upper-RAM storage apart from an aliased path. Random acknowledge delays check the stall and the response timing.

// File: rtl/dmem_router_pkg.sv
package dmem_router_pkg;

  typedef enum logic [1:0] {
    KIND_DIRECT   = 2'd0,
    KIND_INDIRECT = 2'd1,
    KIND_XMOVE    = 2'd2,
    KIND_ALIAS    = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    TGT_SCRATCH = 2'd0,
    TGT_SFR     = 2'd1,
    TGT_XRAM    = 2'd2,
    TGT_EXT     = 2'd3
  } acc_tgt_e;

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_router_pkg::*;
#(
  parameter int AW         = 16,
  parameter int SPLIT_BIT  = 7,
  parameter int XRAM_DEPTH = 768
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic          xram_off,
  output acc_tgt_e      tgt
);

  localparam logic [AW-1:0] XRAM_LIMIT = AW'(XRAM_DEPTH);

  always_comb begin
    unique case (kind)
      KIND_INDIRECT: tgt = TGT_SCRATCH;
      KIND_XMOVE:    tgt = (!xram_off && (addr < XRAM_LIMIT)) ? TGT_XRAM : TGT_EXT;
      default:       tgt = addr[SPLIT_BIT] ? TGT_SFR : TGT_SCRATCH;
    endcase
  end

endmodule

// File: rtl/dmem_sram.sv
module dmem_sram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int AWL   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           we,
  input  logic [AWL-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

  AST_SRAM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (32'(addr) < DEPTH)) else $error("array index out of range"); // R4

endmodule

// File: rtl/dmem_ext_port.sv
module dmem_ext_port #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          busy,
  output logic          ext_req,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic          ext_ack,
  input  logic [DW-1:0] ext_rdata,
  output logic          done,
  output logic [DW-1:0] done_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_req   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
      done      <= 1'b0;
      done_data <= '0;
    end else begin
      done <= ext_req && ext_ack;
      if (!ext_req && start) begin
        ext_req   <= 1'b1;
        ext_we    <= start_we;
        ext_addr  <= start_addr;
        ext_wdata <= start_wdata;
      end else if (ext_req && ext_ack) begin
        ext_req   <= 1'b0;
        done_data <= ext_rdata;
      end
    end
  end

  assign busy = ext_req;

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)
                               && $stable(ext_wdata))) else $error("ext request dropped"); // R8
  AST_EXT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> (done && !ext_req)) else $error("ext completion lost"); // R8
  AST_EXT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ext_req) |=> ext_req) else $error("ext request not raised"); // R8

endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_router_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 8,
  parameter int SCRATCH_DEPTH = 256,
  parameter int XRAM_DEPTH    = 768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xram_off,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sfr_en,
  output logic          sfr_we,
  output logic [7:0]    sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata,
  output logic          ext_req,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic          ext_ack,
  input  logic [DW-1:0] ext_rdata
);

  localparam int SAW       = $clog2(SCRATCH_DEPTH);
  localparam int XAW       = $clog2(XRAM_DEPTH);
  localparam int SPLIT_BIT = SAW - 1;

  acc_tgt_e      tgt;
  logic          accept;
  logic          scratch_en, xram_en, ext_start;
  logic          ext_busy, ext_done;
  logic [DW-1:0] scratch_q, xram_q, ext_q, sfr_q;
  logic          onchip_rsp;
  acc_tgt_e      rsp_tgt;

  dmem_decode #(.AW(AW), .SPLIT_BIT(SPLIT_BIT), .XRAM_DEPTH(XRAM_DEPTH)) u_decode (
    .kind     (req_kind),
    .addr     (req_addr),
    .xram_off (xram_off),
    .tgt      (tgt)
  );

  assign req_ready  = !ext_busy;
  assign accept     = req_valid && req_ready;
  assign scratch_en = accept && (tgt == TGT_SCRATCH);
  assign xram_en    = accept && (tgt == TGT_XRAM);
  assign ext_start  = accept && (tgt == TGT_EXT);

  assign sfr_en    = accept && (tgt == TGT_SFR);
  assign sfr_we    = req_write;
  assign sfr_addr  = req_addr[7:0];
  assign sfr_wdata = req_wdata;

  dmem_sram #(.DEPTH(SCRATCH_DEPTH), .DW(DW)) u_scratch (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (scratch_en),
    .we    (req_write),
    .addr  (req_addr[SAW-1:0]),
    .wdata (req_wdata),
    .rdata (scratch_q)
  );

  dmem_sram #(.DEPTH(XRAM_DEPTH), .DW(DW)) u_xram (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (xram_en),
    .we    (req_write),
    .addr  (req_addr[XAW-1:0]),
    .wdata (req_wdata),
    .rdata (xram_q)
  );

  dmem_ext_port #(.AW(AW), .DW(DW)) u_ext (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ext_start),
    .start_we    (req_write),
    .start_addr  (req_addr),
    .start_wdata (req_wdata),
    .busy        (ext_busy),
    .ext_req     (ext_req),
    .ext_we      (ext_we),
    .ext_addr    (ext_addr),
    .ext_wdata   (ext_wdata),
    .ext_ack     (ext_ack),
    .ext_rdata   (ext_rdata),
    .done        (ext_done),
    .done_data   (ext_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onchip_rsp <= 1'b0;
      rsp_tgt    <= TGT_SCRATCH;
      sfr_q      <= '0;
    end else begin
      onchip_rsp <= accept && (tgt != TGT_EXT);
      if (accept) rsp_tgt <= tgt;
      if (sfr_en && !req_write) sfr_q <= sfr_rdata;
    end
  end

  assign rsp_valid = onchip_rsp || ext_done;

  always_comb begin
    if (ext_done) rsp_rdata = ext_q;
    else begin
      unique case (rsp_tgt)
        TGT_SFR:  rsp_rdata = sfr_q;
        TGT_XRAM: rsp_rdata = xram_q;
        default:  rsp_rdata = scratch_q;
      endcase
    end
  end

  AST_NO_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_en && scratch_en)) else $error("SFR and scratch both selected"); // R3
  AST_ONCHIP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ext_start) |=> rsp_valid) else $error("on-chip response late"); // R7
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !req_ready) else $error("ready while external pending"); // R8
  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(onchip_rsp && ext_done)) else $error("two responses at once"); // R8
  AST_XOFF_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    xram_off |-> !xram_en) else $error("expanded RAM used while bypassed"); // R6

endmodule

// File: tb/dmem_router_test.sv
module dmem_router_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xram_off = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        sfr_en, sfr_we;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        ext_req, ext_we;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_ack = 1'b0;
  logic [7:0]  ext_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dmem_router uut (.*);

  // SFR file driven by the router's SFR port
  logic [7:0] sfr_file [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) sfr_file[i] <= 8'(i) ^ 8'h3C;
    end else if (sfr_en && sfr_we) sfr_file[sfr_addr] <= sfr_wdata;
  end
  assign sfr_rdata = sfr_file[sfr_addr];

  // external device model with random wait
  int        ext_cnt = 0;
  logic [15:0] ext_last_addr = '0;
  logic        ext_last_we = 1'b0;
  logic [7:0]  ext_last_wdata = '0;
  int          ext_wait = 0;
  int          stall_bad = 0;
  int          sfr_strobes = 0;

  function automatic logic [7:0] ext_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(negedge clk) begin
    if (ext_req && req_ready) stall_bad <= stall_bad + 1;
    if (sfr_en) sfr_strobes <= sfr_strobes + 1;
    if (ext_ack) ext_ack <= 1'b0;
    else if (ext_req) begin
      if (ext_wait == 0) begin
        ext_ack        <= 1'b1;
        ext_rdata      <= ext_val(ext_addr);
        ext_cnt        <= ext_cnt + 1;
        ext_last_addr  <= ext_addr;
        ext_last_we    <= ext_we;
        ext_last_wdata <= ext_wdata;
        ext_wait       <= int'($urandom % 4);
      end else ext_wait <= ext_wait - 1;
    end
  end

  // reference models
  logic [7:0] scr_m [256];
  logic [7:0] xr_m  [768];
  logic [7:0] sfr_m [256];

  // 0 scratch, 1 sfr, 2 xram, 3 ext
  function automatic int exp_tgt(input logic [1:0] k, input logic [15:0] a, input logic off);
    if (k == 2'd1) return 0;
    if (k == 2'd2) return (!off && a < 16'h0300) ? 2 : 3;
    return a[7] ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_acc(input logic [1:0] k, input logic [15:0] a, input logic w,
                        input logic [7:0] d, input logic off,
                        output logic [7:0] rd, output int lat, output bit went_ext);
    int c0;
    int s0;
    @(negedge clk);
    c0 = ext_cnt;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_write = w; req_wdata = d;
    xram_off = off;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    s0 = 0;
    went_ext = (ext_cnt != c0);
  endtask

  // full access with reference checking
  task automatic run(input logic [1:0] k, input logic [15:0] a, input logic w,
                     input logic [7:0] d, input logic off);
    logic [7:0] rd;
    int lat;
    bit ex;
    int t;
    t = exp_tgt(k, a, off);
    do_acc(k, a, w, d, off, rd, lat, ex);
    if (t == 3) begin
      chk(ex, "R5/R6 external routing", ex, 1);
      chk(ext_last_addr == a, "R5 ext address", ext_last_addr, a);
      chk(lat >= 1 && lat < 100, "R8 ext response after ack", lat, 1);
      if (w) chk(ext_last_we && ext_last_wdata == d, "R8 ext write byte", ext_last_wdata, d);
      else   chk(rd == ext_val(a), "R8 ext read data", rd, ext_val(a));
    end else begin
      chk(!ex, "R4 on-chip stays off bus", ex, 0);
      chk(lat == 0, "R7 next-cycle response", lat, 0);
      if (w) begin
        if (t == 0) scr_m[a[7:0]] = d;
        else if (t == 1) sfr_m[a[7:0]] = d;
        else xr_m[a[9:0]] = d;
      end else begin
        if (t == 0) chk(rd == scr_m[a[7:0]], "R1/R2/R9 scratch read", rd, scr_m[a[7:0]]);
        else if (t == 1) chk(rd == sfr_m[a[7:0]], "R3/R10 SFR read", rd, sfr_m[a[7:0]]);
        else chk(rd == xr_m[a[9:0]], "R4 expanded RAM read", rd, xr_m[a[9:0]]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) sfr_m[i] = 8'(i) ^ 8'h3C;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "reset rsp_valid", rsp_valid, 0);
    chk(ext_req == 1'b0, "reset ext_req", ext_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill on-chip arrays
    for (int i = 0; i < 256; i++) run(2'd1, 16'(i), 1'b1, 8'($urandom), 1'b0);
    for (int i = 0; i < 768; i++) run(2'd2, 16'(i), 1'b1, 8'($urandom), 1'b0);

    // R3: direct and indirect writes at same byte must not alias
    s0 = sfr_strobes;
    run(2'd0, 16'h0090, 1'b1, 8'h11, 1'b0);
    run(2'd1, 16'h0090, 1'b1, 8'h22, 1'b0);
    run(2'd0, 16'h0090, 1'b0, 8'h00, 1'b0);
    run(2'd1, 16'h0090, 1'b0, 8'h00, 1'b0);
    chk(sfr_strobes - s0 == 2, "R3 SFR strobes only for direct", sfr_strobes - s0, 2);
    chk(sfr_file[8'h90] == 8'h11, "R3 SFR holds direct value", sfr_file[8'h90], 8'h11);
    // R2: indirect upper access leaves SFR port idle
    s0 = sfr_strobes;
    run(2'd1, 16'h00FF, 1'b0, 8'h00, 1'b0);
    chk(sfr_strobes == s0, "R2 indirect upper no SFR strobe", sfr_strobes - s0, 0);
    // R1: lower byte shared by direct and indirect
    run(2'd0, 16'h0042, 1'b1, 8'h5E, 1'b0);
    run(2'd1, 16'h0042, 1'b0, 8'h00, 1'b0);
    // R10 and R9: kind 3 with junk high bits acts as direct
    run(2'd3, 16'hAB90, 1'b0, 8'h00, 1'b0);
    run(2'd3, 16'h7712, 1'b1, 8'hC3, 1'b0);
    run(2'd0, 16'h0012, 1'b0, 8'h00, 1'b0);
    // R4 boundary
    run(2'd2, 16'h02FF, 1'b0, 8'h00, 1'b0);
    run(2'd2, 16'h0300, 1'b0, 8'h00, 1'b0);
    run(2'd2, 16'hFFFF, 1'b1, 8'h99, 1'b0);
    // R6: bypass leaves expanded RAM untouched
    run(2'd2, 16'h0010, 1'b1, 8'hEE, 1'b1);
    run(2'd2, 16'h0010, 1'b0, 8'h00, 1'b1);
    run(2'd2, 16'h0010, 1'b0, 8'h00, 1'b0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [1:0]  k;
      logic [15:0] a;
      k = 2'($urandom);
      if (k == 2'd2) a = ($urandom % 3 == 0) ? 16'($urandom) : 16'(16'h0200 + $urandom % 16'h0200);
      else a = 16'($urandom);
      run(k, a, 1'($urandom), 8'($urandom), ($urandom % 4) == 0);
    end

    chk(stall_bad == 0, "R8 ready low while ext pending", stall_bad, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule